// File: doc/BRIEF.md
# Vector Scalar-Add Memory Engine

This block carries out one vector command of the form `dst[i] = src[i] + k` over a run of data words held in memory. A controller loads a source base address, a destination base address, an element count and the scalar `k`, then pulses `start`. From that point the engine needs no further commands. It steps through the elements one after another over a single synchronous memory port. For each element it issues a read, and in the next cycle it adds the scalar to the returned word and writes the sum back. After the last write it raises `done` for one cycle.

Both address streams are byte addresses. Each one moves forward by the word size in bytes for every element, and each wraps at the top of the address space. The port has one cycle of read latency, so every element takes two cycles, and the datapath never produces more than one result per cycle. The engine captures its operands when it accepts a command, so the command inputs may change while a run is in progress. `busy` stays high from acceptance to the end of the completion cycle. Any `start` pulse that arrives while `busy` is high has no effect.

Top module: `vsadd_engine`

## Requirements
- R1: While reset is applied and after it is released, with no command given, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: A command with count N > 0 produces N read cycles. Read i (counting from 0) presents address `src_base + i*BYTES` on `mem_addr`, where BYTES = DATA_W/8. The first read occurs in the cycle after `start` is sampled.
- R3: Every read cycle is followed at once by a write cycle. That write presents address `dst_base + i*BYTES` and data equal to the word returned by the read plus the scalar, taken modulo 2^DATA_W.
- R4: `mem_rd_en` and `mem_wr_en` are never high in the same cycle, and neither is high while `busy` is 0.
- R5: `done` is high for exactly one cycle, the cycle after the last write. `busy` is high from the cycle after acceptance through the `done` cycle and is 0 in the cycle that follows.
- R6: A count of 0 raises `done` in the cycle after `start` and makes no memory access.
- R7: A `start` pulse sampled while `busy` is high, including in the `done` cycle, is ignored. The run in progress is unchanged and no new run follows.
- R8: The source and destination addresses wrap modulo 2^ADDR_W.
- R9: The base addresses, count and scalar are captured when a command is accepted. Later changes to those inputs do not affect the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command pulse, accepted only when not busy |
| src_base | input | ADDR_W | Byte address of the first source element |
| dst_base | input | ADDR_W | Byte address of the first destination element |
| elem_count | input | CNT_W | Number of elements to process |
| scalar | input | DATA_W | Value added to every element |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Memory read strobe, data returns one cycle later |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Shared byte address for reads and writes |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd_en` |

## Verification
The bench builds the engine with ADDR_W = 12, DATA_W = 32 and CNT_W = 5. The 12-bit address space can be modelled in full by a memory of 1024 words. This makes the address wrap at 0xFFC reachable with a short run. The 5-bit count lets the bench run the largest command, 31 elements, in a few dozen cycles. The 32-bit data width keeps the modular add at its true size, so a scalar of all ones applied to nonzero data exercises carry-out wrap. Overlapping source and destination ranges are also exercised, and the reference model replays those element by element.

// File: rtl/vsadd_pkg.sv
package vsadd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_READ      = 2'd1,
    ST_ADD_WRITE = 2'd2,
    ST_DONE      = 2'd3
  } vs_state_e;

endpackage

// File: rtl/vsadd_seq.sv
module vsadd_seq
  import vsadd_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] elem_count,
  output vs_state_e        state,
  output logic             cmd_accept,
  output logic             cmd_zero,
  output logic             elem_step,
  output logic             last_elem
);

  logic [CNT_W-1:0] remaining;
  vs_state_e        state_nx;

  assign cmd_accept = (state == ST_IDLE) && start;
  assign cmd_zero   = (elem_count == '0);
  assign elem_step  = (state == ST_ADD_WRITE);
  assign last_elem  = (remaining == CNT_W'(1));

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:      if (cmd_accept) state_nx = cmd_zero ? ST_DONE : ST_READ;
      ST_READ:      state_nx = ST_ADD_WRITE;
      ST_ADD_WRITE: state_nx = last_elem ? ST_DONE : ST_READ;
      ST_DONE:      state_nx = ST_IDLE;
      default:      state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      remaining <= '0;
    end else begin
      state <= state_nx;
      if (cmd_accept)     remaining <= elem_count;
      else if (elem_step) remaining <= remaining - CNT_W'(1);
    end
  end

endmodule

// File: rtl/vsadd_agen.sv
module vsadd_agen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  output logic [ADDR_W-1:0] ptr
);

  function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(STRIDE);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (load)    ptr <= base;
    else if (advance) ptr <= step_ptr(ptr);
  end

endmodule

// File: rtl/vsadd_alu.sv
module vsadd_alu #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] elem,
  input  logic [DATA_W-1:0] addend,
  output logic [DATA_W-1:0] sum
);

  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  assign sum = wrap_add(elem, addend);

endmodule

// File: rtl/vsadd_engine.sv
module vsadd_engine
  import vsadd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [CNT_W-1:0]  elem_count,
  input  logic [DATA_W-1:0] scalar,
  output logic              busy,
  output logic              done,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int unsigned WORD_BYTES = DATA_W / 8;

  vs_state_e         state;
  logic              cmd_accept;
  logic              cmd_zero;
  logic              elem_step;
  logic              last_elem;
  logic [ADDR_W-1:0] src_ptr;
  logic [ADDR_W-1:0] dst_ptr;
  logic [DATA_W-1:0] scalar_q;

  vsadd_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .elem_count (elem_count),
    .state      (state),
    .cmd_accept (cmd_accept),
    .cmd_zero   (cmd_zero),
    .elem_step  (elem_step),
    .last_elem  (last_elem)
  );

  vsadd_agen #(.ADDR_W(ADDR_W), .STRIDE(WORD_BYTES)) u_src_agen (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cmd_accept),
    .base    (src_base),
    .advance (elem_step),
    .ptr     (src_ptr)
  );

  vsadd_agen #(.ADDR_W(ADDR_W), .STRIDE(WORD_BYTES)) u_dst_agen (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cmd_accept),
    .base    (dst_base),
    .advance (elem_step),
    .ptr     (dst_ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          scalar_q <= '0;
    else if (cmd_accept) scalar_q <= scalar;
  end

  vsadd_alu #(.DATA_W(DATA_W)) u_alu (
    .elem   (mem_rdata),
    .addend (scalar_q),
    .sum    (mem_wdata)
  );

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign mem_rd_en = (state == ST_READ);
  assign mem_wr_en = elem_step;
  assign mem_addr  = elem_step ? dst_ptr : src_ptr;

endmodule

// File: rtl/vsadd_chk.sv
module vsadd_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              cmd_accept,
  input logic              cmd_zero
);

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !mem_wr_en));

  p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_wr_en);

  p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en));

  p_src_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_wr_en)) |->
      ((mem_addr - $past(mem_addr, 2)) == ADDR_W'(4)));

  p_dst_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && $past(mem_wr_en, 2)) |->
      ((mem_addr - $past(mem_addr, 2)) == ADDR_W'(4)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_zero_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && cmd_zero) |=> (done && !mem_rd_en && !mem_wr_en));

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

bind vsadd_engine vsadd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .mem_rd_en  (mem_rd_en),
  .mem_wr_en  (mem_wr_en),
  .mem_addr   (mem_addr),
  .cmd_accept (cmd_accept),
  .cmd_zero   (cmd_zero)
);

// File: tb/sim_vsadd_engine.sv
`timescale 1ns/1ps
module sim_vsadd_engine;

  localparam int AW = 12;
  localparam int DW = 32;
  localparam int CW = 5;
  localparam int WORDS = 1 << (AW - 2);

  typedef struct {
    bit            rd;
    bit            wr;
    bit            dn;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } op_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] src_base = '0;
  logic [AW-1:0] dst_base = '0;
  logic [CW-1:0] elem_count = '0;
  logic [DW-1:0] scalar = '0;
  logic          busy, done, mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int accesses = 0;
  logic [DW-1:0] bus_mem [WORDS];
  logic [DW-1:0] ref_mem [WORDS];
  op_t q[$];
  bit  cur_busy = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  vsadd_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base),
    .dst_base(dst_base), .elem_count(elem_count), .scalar(scalar),
    .busy(busy), .done(done), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s): actual %h expected %h at %0t", req, tag, act, exp, $time);
    end
  endtask

  // memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= bus_mem[mem_addr[AW-1:2]];
    if (mem_wr_en) bus_mem[mem_addr[AW-1:2]] <= mem_wdata;
    if (rst_n && (mem_rd_en || mem_wr_en)) accesses++;
  end

  // reference model: accepts a command when idle, expands it into ops
  always @(posedge clk) begin
    if (rst_n && !cur_busy && start) begin
      for (int i = 0; i < int'(elem_count); i++) begin
        op_t r, w;
        logic [AW-1:0] sa, da;
        logic [DW-1:0] v;
        sa = src_base + AW'(4 * i);
        da = dst_base + AW'(4 * i);
        v  = ref_mem[sa[AW-1:2]];
        r = '{rd: 1'b1, wr: 1'b0, dn: 1'b0, addr: sa, data: '0};
        w = '{rd: 1'b0, wr: 1'b1, dn: 1'b0, addr: da, data: v + scalar};
        ref_mem[da[AW-1:2]] = v + scalar;
        q.push_back(r);
        q.push_back(w);
      end
      q.push_back('{rd: 1'b0, wr: 1'b0, dn: 1'b1, addr: '0, data: '0});
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!busy && !done && !mem_rd_en && !mem_wr_en, "R1",
          {busy, done, mem_rd_en, mem_wr_en}, 0);
    end else if (q.size() > 0) begin
      op_t e;
      e = q.pop_front();
      cur_busy = 1'b1;
      chk(busy == 1'b1, "R5 busy", busy, 1);
      chk(mem_rd_en == e.rd, "R2 rd_en", mem_rd_en, e.rd);
      chk(mem_wr_en == e.wr, "R3 wr_en", mem_wr_en, e.wr);
      chk(done == e.dn, "R5 done", done, e.dn);
      chk(!(mem_rd_en && mem_wr_en), "R4 exclusive", {mem_rd_en, mem_wr_en}, 0);
      if (e.rd) chk(mem_addr == e.addr, "R2 src addr", mem_addr, e.addr);
      if (e.wr) begin
        chk(mem_addr == e.addr, "R3 dst addr", mem_addr, e.addr);
        chk(mem_wdata == e.data, "R3 data", mem_wdata, e.data);
      end
    end else begin
      cur_busy = 1'b0;
      chk(!busy && !done, "R5 idle", {busy, done}, 0);
      chk(!mem_rd_en && !mem_wr_en, "R4 idle quiet", {mem_rd_en, mem_wr_en}, 0);
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic set_cmd(input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input int n, input logic [DW-1:0] k);
    src_base = s; dst_base = d; elem_count = CW'(n); scalar = k;
  endtask

  task automatic pulse();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() > 0 || cur_busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic mem_match(input string req);
    int bad = 0;
    for (int i = 0; i < WORDS; i++) if (bus_mem[i] !== ref_mem[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      bus_mem[i] = (i * 32'h0101_0101) ^ 32'hA5A5_0000;
      ref_mem[i] = bus_mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2, R3: basic run
    tag = "R2 basic";
    set_cmd(12'h100, 12'h400, 3, 32'd7);
    pulse(); wait_idle(); mem_match("R3 memory");

    // R6: zero count
    tag = "R6 zero";
    accesses = 0;
    set_cmd(12'h200, 12'h600, 0, 32'd1);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R6 done", done, 1);
    wait_idle();
    chk(accesses == 0, "R6 no access", accesses, 0);

    // R3: modular wrap of the add
    tag = "R3 wrap";
    set_cmd(12'h040, 12'h800, 4, 32'hFFFF_FFFF);
    pulse(); wait_idle(); mem_match("R3 modulo");

    // R7, R9: start while busy, inputs changed mid-run
    tag = "R7 R9";
    set_cmd(12'h300, 12'h500, 6, 32'h10);
    pulse();
    repeat (3) @(posedge clk);
    #1 set_cmd(12'h000, 12'h000, 9, 32'hDEAD);
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_idle(); mem_match("R9 captured");

    // R7: start sampled in the done cycle
    tag = "R7 done cycle";
    set_cmd(12'h080, 12'h900, 1, 32'd3);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(posedge clk);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_idle();
    chk(busy == 1'b0, "R7 no new run", busy, 0);

    // R8: address wrap at the top of the space
    tag = "R8";
    set_cmd(12'hFF8, 12'hFFC, 3, 32'd5);
    pulse(); wait_idle(); mem_match("R8 wrap");
    chk(bus_mem[1] == ref_mem[1], "R8 slot 1", bus_mem[1], ref_mem[1]);

    // in-place and overlapping ranges
    tag = "R3 overlap";
    set_cmd(12'h700, 12'h700, 5, 32'd2);
    pulse(); wait_idle();
    set_cmd(12'h700, 12'h704, 4, 32'd1);
    pulse(); wait_idle(); mem_match("R3 overlap");

    // R2: largest count, back-to-back commands
    tag = "R2 max";
    set_cmd(12'hA00, 12'hC00, 31, 32'h1234_5678);
    pulse(); wait_idle();
    set_cmd(12'hC00, 12'hA00, 31, 32'h1);
    pulse(); wait_idle(); mem_match("R2 max");

    finish_run();
  end

endmodule